// File: doc/BRIEF.md
# Flash Lock-Bit Command Controller

This block is the command decoder and write sequencer for the lock-bit side of a parallel flash device. A host writes command bytes with an address on a one-cycle write strobe. Three lock operations are accepted, each as a setup byte followed by a confirm byte: lock one block, set the device-wide permanent lock, and unlock every block at once. Each accepted confirm starts a busy period of a fixed number of clocks. When that period ends, the lock state is updated and the result is posted in a status register. Reads return either the array data supplied from outside or the status byte, depending on the current read mode.

The block keeps one lock bit per block and a single permanent lock bit. Once the permanent lock bit is set, it freezes the block lock bits against any further change. The permanent bit is cleared only by the storage initialisation input `por_n`, which stands for a blank device. The device reset `rst_n` only returns the controller to array reads. A separate permit output tells the program/erase path whether the block it targets may be written. Any refused or invalid sequence sets its own pair of sticky error bits. If the programming voltage is low when a lock confirm (0x01 or 0xF1) arrives, the set error and the voltage error are raised.

States: `S_ARRAY` (reads give array data), `S_STATUS` (reads give status), `S_SETUP` (setup seen, waiting for confirm), `S_BUSY` (operation running). Transitions: ARRAY/STATUS to SETUP on 0x60. ARRAY/STATUS to STATUS on 0x70. ARRAY/STATUS to ARRAY on 0xFF. SETUP to BUSY on a valid confirm byte. SETUP to STATUS on any other byte. BUSY to STATUS when the busy count expires. Any state to ARRAY on reset.

Top module: `flk_lock_ctrl`

## Requirements
- R1: After `rst_n` is released, reads return `arr_rdata`, `ready` is 1 and all error bits read 0. `rst_n` leaves `blk_lock` and `perm_lock` unchanged.
- R2: Command 0x70 selects status reads and 0xFF selects array reads. The status byte layout is: bit 7 ready, bit 5 unlock error, bit 4 lock error, bit 3 voltage error, bit 1 protection error, and all other bits 0.
- R3: Writing 0x60 and then 0x01 sets the lock bit of the block addressed by the top log2(NBLK) bits of the confirm address.
- R4: After a valid confirm, `ready` and status bit 7 read 0 for exactly BUSY_CYC cycles. Writes made during that time are ignored. The lock update and the return to ready happen on the same edge, and the controller is then in status mode.
- R5: Writing 0x60 and then 0xF1 with any address sets `perm_lock`. Neither `rst_n` nor any command clears it.
- R6: Writing 0x60 and then 0xD0 clears every block lock bit together.
- R7: Any byte other than 0x01, 0xF1 or 0xD0 after 0x60 sets status bits 4 and 5, starts no busy period and changes no lock bit.
- R8: While `perm_lock` is 1, a block lock sets status bits 1 and 4, an unlock sets bits 1 and 5, and the block lock bits do not change.
- R9: An unlock confirmed while `vpp_ok` is 0 sets status bits 3 and 5 and leaves the lock bits unchanged.
- R10: Error bits accumulate and stay set until command 0x50, which clears them without changing the read mode.
- R11: `pe_permit` is 0 exactly when `wp_on` is 1 and the lock bit of block `pe_block` is set.
- R12: Status mode holds across any number of idle cycles until a new command is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Storage initialisation, active low; clears all lock bits |
| rst_n | input | 1 | Device reset, active low; returns to array reads |
| we | input | 1 | One-cycle write strobe |
| wr_addr | input | AW | Write address; top bits select the block |
| wr_data | input | 8 | Command byte |
| vpp_ok | input | 1 | Programming voltage above lockout |
| arr_rdata | input | 8 | Array data presented in array mode |
| rd_data | output | 8 | Read data: array or status byte |
| ready | output | 1 | 1 when no operation is running |
| blk_lock | output | NBLK | Per-block lock bits |
| perm_lock | output | 1 | Permanent lock bit |
| wp_on | input | 1 | Write protect asserted |
| pe_block | input | log2(NBLK) | Block targeted by program/erase |
| pe_permit | output | 1 | Program/erase allowed on `pe_block` |

## Verification
Read-mode and error-bit results appear one edge after the write that causes them. Lock bit changes and the return of `ready` appear BUSY_CYC edges after the confirm edge. The permit output follows its inputs in the same cycle. The bench drives each write over one rising edge. It then samples at the following falling edge, or waits BUSY_CYC more falling edges after a confirm, so each comparison falls in the first cycle in which its result is due. The busy test samples `ready` at every falling edge of the window, so an early or late release is caught.

// File: rtl/flk_pkg.sv
package flk_pkg;

    typedef enum logic [1:0] {
        S_ARRAY,
        S_STATUS,
        S_SETUP,
        S_BUSY
    } flk_state_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_BLK,
        OP_PERM,
        OP_CLR
    } flk_op_e;

    localparam logic [7:0] CMD_SETUP     = 8'h60;
    localparam logic [7:0] CMD_CONF_BLK  = 8'h01;
    localparam logic [7:0] CMD_CONF_PERM = 8'hF1;
    localparam logic [7:0] CMD_CONF_CLR  = 8'hD0;
    localparam logic [7:0] CMD_CLR_SR    = 8'h50;
    localparam logic [7:0] CMD_RD_SR     = 8'h70;
    localparam logic [7:0] CMD_RD_ARR    = 8'hFF;

    // compact error vector: [0] protection, [1] voltage, [2] lock, [3] unlock
    localparam logic [3:0] ERRM_PROT = 4'b0001;
    localparam logic [3:0] ERRM_VPP  = 4'b0010;
    localparam logic [3:0] ERRM_SET  = 4'b0100;
    localparam logic [3:0] ERRM_CLR  = 4'b1000;

    function automatic logic [7:0] sr_pack(input logic rdy, input logic [3:0] e);
        return {rdy, 1'b0, e[3], e[2], e[1], 1'b0, e[0], 1'b0};
    endfunction

endpackage

// File: rtl/flk_cmd_fsm.sv
module flk_cmd_fsm
    import flk_pkg::*;
#(
    parameter int BW       = 3,
    parameter int BUSY_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [BW-1:0]    wr_blk,
    input  logic [7:0]       wr_data,
    input  logic             vpp_ok,
    input  logic             perm_lock,
    output logic             status_mode,
    output logic             busy,
    output logic [3:0]       err_o,
    output logic             apply_en,
    output flk_op_e          apply_op,
    output logic [BW-1:0]    apply_blk
);

    localparam int CW = $clog2(BUSY_CYC + 1);

    flk_state_e     state_q, state_d;
    logic [CW-1:0]  cnt_q, cnt_d;
    flk_op_e        op_q, op_d;
    logic [BW-1:0]  blk_q, blk_d;
    logic [3:0]     perr_q, perr_d;
    logic [3:0]     err_q, err_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        op_d    = op_q;
        blk_d   = blk_q;
        perr_d  = perr_q;
        err_d   = err_q;
        unique case (state_q)
            S_ARRAY, S_STATUS: begin
                if (we) begin
                    if (wr_data == CMD_SETUP)       state_d = S_SETUP;
                    else if (wr_data == CMD_RD_SR)  state_d = S_STATUS;
                    else if (wr_data == CMD_RD_ARR) state_d = S_ARRAY;
                    else if (wr_data == CMD_CLR_SR) err_d   = '0;
                end
            end
            S_SETUP: begin
                if (we) begin
                    cnt_d   = CW'(BUSY_CYC - 1);
                    blk_d   = wr_blk;
                    perr_d  = '0;
                    op_d    = OP_NONE;
                    state_d = S_BUSY;
                    if (wr_data == CMD_CONF_BLK) begin
                        if (!vpp_ok)        perr_d = ERRM_VPP | ERRM_SET;
                        else if (perm_lock) perr_d = ERRM_PROT | ERRM_SET;
                        else                op_d   = OP_BLK;
                    end else if (wr_data == CMD_CONF_PERM) begin
                        if (!vpp_ok)        perr_d = ERRM_VPP | ERRM_SET;
                        else                op_d   = OP_PERM;
                    end else if (wr_data == CMD_CONF_CLR) begin
                        if (!vpp_ok)        perr_d = ERRM_VPP | ERRM_CLR;
                        else if (perm_lock) perr_d = ERRM_PROT | ERRM_CLR;
                        else                op_d   = OP_CLR;
                    end else begin
                        state_d = S_STATUS;
                        err_d   = err_q | ERRM_SET | ERRM_CLR;
                    end
                end
            end
            S_BUSY: begin
                if (cnt_q == '0) begin
                    state_d = S_STATUS;
                    err_d   = err_q | perr_q;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_ARRAY;
            cnt_q   <= '0;
            op_q    <= OP_NONE;
            blk_q   <= '0;
            perr_q  <= '0;
            err_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            op_q    <= op_d;
            blk_q   <= blk_d;
            perr_q  <= perr_d;
            err_q   <= err_d;
        end
    end

    always_comb begin
        status_mode = (state_q != S_ARRAY);
        busy        = (state_q == S_BUSY);
        err_o       = err_q;
        apply_en    = (state_q == S_BUSY) && (cnt_q == '0);
        apply_op    = op_q;
        apply_blk   = blk_q;
    end

    logic clr_cmd;
    assign clr_cmd = we && (wr_data == CMD_CLR_SR)
                     && (state_q == S_ARRAY || state_q == S_STATUS);

    assert_busy_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_BUSY) |=> (state_q == S_BUSY || state_q == S_STATUS));

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_cmd |=> ((err_q & $past(err_q)) == $past(err_q)));

    assert_bad_confirm_no_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SETUP && we && wr_data != CMD_CONF_BLK
         && wr_data != CMD_CONF_PERM && wr_data != CMD_CONF_CLR)
        |=> (state_q == S_STATUS && err_q[3] && err_q[2]));

endmodule

// File: rtl/flk_lock_store.sv
module flk_lock_store
    import flk_pkg::*;
#(
    parameter int NBLK = 8,
    parameter int BW   = 3
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             apply_en,
    input  flk_op_e          apply_op,
    input  logic [BW-1:0]    apply_blk,
    output logic [NBLK-1:0]  blk_lock_o,
    output logic             perm_o
);

    logic [NBLK-1:0] blk_q;
    logic            perm_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            blk_q  <= '0;
            perm_q <= 1'b0;
        end else if (apply_en) begin
            unique case (apply_op)
                OP_NONE: ;
                OP_BLK:  if (!perm_q) blk_q[apply_blk] <= 1'b1;
                OP_PERM: perm_q <= 1'b1;
                OP_CLR:  if (!perm_q) blk_q <= '0;
            endcase
        end
    end

    assign blk_lock_o = blk_q;
    assign perm_o     = perm_q;

    assert_perm_sticky_R5: assert property (@(posedge clk) disable iff (!por_n)
        perm_q |=> perm_q);

    assert_frozen_locks_R8: assert property (@(posedge clk) disable iff (!por_n)
        perm_q |=> $stable(blk_q));

    assert_update_only_on_apply_R4: assert property (@(posedge clk) disable iff (!por_n)
        !apply_en |=> $stable(blk_q));

endmodule

// File: rtl/flk_permit.sv
module flk_permit #(
    parameter int NBLK = 8,
    parameter int BW   = 3
) (
    input  logic [NBLK-1:0] blk_lock,
    input  logic [BW-1:0]   pe_block,
    input  logic            wp_on,
    output logic            pe_permit
);

    logic [NBLK-1:0] deny;

    for (genvar g = 0; g < NBLK; g++) begin : g_gate
        assign deny[g] = wp_on && blk_lock[g] && (pe_block == BW'(g));
    end

    assign pe_permit = ~|deny;

endmodule

// File: rtl/flk_lock_ctrl.sv
module flk_lock_ctrl
    import flk_pkg::*;
#(
    parameter int NBLK     = 8,
    parameter int AW       = 12,
    parameter int BUSY_CYC = 4,
    localparam int BW      = $clog2(NBLK)
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    wr_addr,
    input  logic [7:0]       wr_data,
    input  logic             vpp_ok,
    input  logic [7:0]       arr_rdata,
    output logic [7:0]       rd_data,
    output logic             ready,
    output logic [NBLK-1:0]  blk_lock,
    output logic             perm_lock,
    input  logic             wp_on,
    input  logic [BW-1:0]    pe_block,
    output logic             pe_permit
);

    logic          ctl_rst_n;
    logic          status_mode;
    logic          busy;
    logic [3:0]    err;
    logic          apply_en;
    flk_op_e       apply_op;
    logic [BW-1:0] apply_blk;
    logic [BW-1:0] wr_blk;
    logic          unused_addr_low;

    assign ctl_rst_n       = rst_n & por_n;
    assign wr_blk          = wr_addr[AW-1 -: BW];
    assign unused_addr_low = ^wr_addr[AW-BW-1:0];

    flk_cmd_fsm #(.BW(BW), .BUSY_CYC(BUSY_CYC)) u_fsm (
        .clk         (clk),
        .rst_n       (ctl_rst_n),
        .we          (we),
        .wr_blk      (wr_blk),
        .wr_data     (wr_data),
        .vpp_ok      (vpp_ok),
        .perm_lock   (perm_lock),
        .status_mode (status_mode),
        .busy        (busy),
        .err_o       (err),
        .apply_en    (apply_en),
        .apply_op    (apply_op),
        .apply_blk   (apply_blk)
    );

    flk_lock_store #(.NBLK(NBLK), .BW(BW)) u_store (
        .clk        (clk),
        .por_n      (por_n),
        .apply_en   (apply_en),
        .apply_op   (apply_op),
        .apply_blk  (apply_blk),
        .blk_lock_o (blk_lock),
        .perm_o     (perm_lock)
    );

    flk_permit #(.NBLK(NBLK), .BW(BW)) u_permit (
        .blk_lock  (blk_lock),
        .pe_block  (pe_block),
        .wp_on     (wp_on),
        .pe_permit (pe_permit)
    );

    assign ready   = !busy;
    assign rd_data = status_mode ? sr_pack(!busy, err) : arr_rdata;

    assert_permit_needs_wp_R11: assert property (@(posedge clk) disable iff (!por_n)
        !pe_permit |-> (wp_on && blk_lock[pe_block]));

    assert_array_after_reset_R1: assert property (@(posedge clk) disable iff (!por_n)
        !rst_n |=> (ready && rd_data == arr_rdata));

endmodule

// File: tb/sim_flk_lock_ctrl.sv
module sim_flk_lock_ctrl;

    localparam int NBLK = 8;
    localparam int AW   = 12;
    localparam int BUSY = 4;
    localparam int BW   = 3;

    logic            clk = 1'b0;
    logic            por_n, rst_n, we, vpp_ok, wp_on;
    logic [AW-1:0]   wr_addr;
    logic [7:0]      wr_data;
    logic [7:0]      arr_rdata;
    logic [7:0]      rd_data;
    logic            ready, perm_lock, pe_permit;
    logic [NBLK-1:0] blk_lock;
    logic [BW-1:0]   pe_block;

    int n_run  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    flk_lock_ctrl #(.NBLK(NBLK), .AW(AW), .BUSY_CYC(BUSY)) u0 (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .we(we), .wr_addr(wr_addr),
        .wr_data(wr_data), .vpp_ok(vpp_ok), .arr_rdata(arr_rdata),
        .rd_data(rd_data), .ready(ready), .blk_lock(blk_lock),
        .perm_lock(perm_lock), .wp_on(wp_on), .pe_block(pe_block),
        .pe_permit(pe_permit)
    );

    // {cmd, block, vpp, wait, exp rd_data, exp blk_lock, exp perm, req}
    localparam int NV = 25;
    localparam logic [35:0] VEC [NV] = '{
        {8'h70, 3'd0, 1'b1, 3'd0, 8'h80, 8'h00, 1'b0, 4'd2},  // R2
        {8'hFF, 3'd0, 1'b1, 3'd0, 8'hA5, 8'h00, 1'b0, 4'd2},  // R2
        {8'h60, 3'd3, 1'b1, 3'd0, 8'h80, 8'h00, 1'b0, 4'd3},  // R3
        {8'h01, 3'd3, 1'b1, 3'd4, 8'h80, 8'h08, 1'b0, 4'd3},  // R3
        {8'h60, 3'd6, 1'b1, 3'd0, 8'h80, 8'h08, 1'b0, 4'd3},
        {8'h01, 3'd6, 1'b1, 3'd4, 8'h80, 8'h48, 1'b0, 4'd3},
        {8'h60, 3'd0, 1'b1, 3'd0, 8'h80, 8'h48, 1'b0, 4'd7},  // R7
        {8'h77, 3'd0, 1'b1, 3'd0, 8'hB0, 8'h48, 1'b0, 4'd7},
        {8'h50, 3'd0, 1'b1, 3'd0, 8'h80, 8'h48, 1'b0, 4'd10}, // R10
        {8'h60, 3'd0, 1'b0, 3'd0, 8'h80, 8'h48, 1'b0, 4'd9},  // R9
        {8'hD0, 3'd0, 1'b0, 3'd4, 8'hA8, 8'h48, 1'b0, 4'd9},
        {8'h50, 3'd0, 1'b1, 3'd0, 8'h80, 8'h48, 1'b0, 4'd10},
        {8'h60, 3'd0, 1'b1, 3'd0, 8'h80, 8'h48, 1'b0, 4'd6},  // R6
        {8'hD0, 3'd0, 1'b1, 3'd4, 8'h80, 8'h00, 1'b0, 4'd6},
        {8'h60, 3'd1, 1'b1, 3'd0, 8'h80, 8'h00, 1'b0, 4'd3},
        {8'h01, 3'd1, 1'b1, 3'd4, 8'h80, 8'h02, 1'b0, 4'd3},
        {8'h60, 3'd5, 1'b1, 3'd0, 8'h80, 8'h02, 1'b0, 4'd5},  // R5
        {8'hF1, 3'd5, 1'b1, 3'd4, 8'h80, 8'h02, 1'b1, 4'd5},
        {8'h60, 3'd0, 1'b1, 3'd0, 8'h80, 8'h02, 1'b1, 4'd8},  // R8
        {8'h01, 3'd0, 1'b1, 3'd4, 8'h92, 8'h02, 1'b1, 4'd8},
        {8'h60, 3'd0, 1'b1, 3'd0, 8'h92, 8'h02, 1'b1, 4'd8},
        {8'hD0, 3'd0, 1'b1, 3'd4, 8'hB2, 8'h02, 1'b1, 4'd8},
        {8'hFF, 3'd0, 1'b1, 3'd0, 8'hA5, 8'h02, 1'b1, 4'd2},
        {8'h70, 3'd0, 1'b1, 3'd0, 8'hB2, 8'h02, 1'b1, 4'd10},
        {8'h50, 3'd0, 1'b1, 3'd0, 8'h80, 8'h02, 1'b1, 4'd10}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // called at a falling edge; the write spans the next rising edge
    task automatic bus_write(input logic [7:0] d, input logic [2:0] b, input logic [8:0] low);
        we      = 1'b1;
        wr_data = d;
        wr_addr = {b, low};
        @(negedge clk);
        we = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        por_n = 1'b0; rst_n = 1'b0; we = 1'b0; wr_addr = '0; wr_data = '0;
        vpp_ok = 1'b1; wp_on = 1'b0; pe_block = '0; arr_rdata = 8'hA5;
        repeat (3) @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", {rd_data, 7'd0, ready, blk_lock, 7'd0, perm_lock},
              {8'hA5, 7'd0, 1'b1, 8'h00, 7'd0, 1'b0});

        for (int i = 0; i < NV; i++) begin
            vpp_ok = VEC[i][24];
            bus_write(VEC[i][35:28], VEC[i][27:25], (VEC[i][35:28] == 8'hF1) ? 9'h1AB : 9'h000);
            repeat (int'(VEC[i][23:21])) @(negedge clk);
            check($sformatf("R%0d vector %0d", VEC[i][3:0], i),
                  {rd_data, blk_lock, 7'd0, perm_lock},
                  {VEC[i][20:13], VEC[i][12:5], 7'd0, VEC[i][4]});
        end
        vpp_ok = 1'b1;

        // R4 busy window, write during busy ignored
        bus_write(8'h60, 3'd2, 9'h0);
        bus_write(8'h01, 3'd2, 9'h0);
        check("R4 busy edge1", {ready, rd_data[7]}, 2'b00);
        bus_write(8'h50, 3'd0, 9'h0);
        check("R4 busy edge2", ready, 1'b0);
        @(negedge clk);
        check("R4 busy edge3", ready, 1'b0);
        @(negedge clk);
        check("R4 busy edge4", ready, 1'b0);
        @(negedge clk);
        check("R4 done", {ready, rd_data, blk_lock}, {1'b1, 8'h92, 8'h02});

        // R12 status mode holds while idle
        repeat (5) @(negedge clk);
        check("R12 hold", rd_data, 8'h92);
        bus_write(8'h50, 3'd0, 9'h0);
        check("R10 clear", rd_data, 8'h80);

        // R1 reset clears errors and mode, keeps locks (R5 survives reset)
        bus_write(8'h60, 3'd0, 9'h0);
        bus_write(8'h33, 3'd0, 9'h0);
        check("R7 bad confirm", {ready, rd_data}, {1'b1, 8'hB0});
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", {rd_data, 7'd0, ready, blk_lock, 7'd0, perm_lock},
              {8'hA5, 7'd0, 1'b1, 8'h02, 7'd0, 1'b1});
        bus_write(8'h70, 3'd0, 9'h0);
        check("R1 errors cleared", rd_data, 8'h80);

        // R11 permit gating
        wp_on = 1'b1; pe_block = 3'd1;
        #1 check("R11 locked+wp", pe_permit, 1'b0);
        pe_block = 3'd0;
        #1 check("R11 unlocked+wp", pe_permit, 1'b1);
        wp_on = 1'b0; pe_block = 3'd1;
        #1 check("R11 locked no wp", pe_permit, 1'b1);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule